// File: doc/BRIEF.md
# Multi-Shot Triggered Capture Sequencer

This block sequences the capture of a sample stream into a circular record buffer. The host loads a pre-trigger length, a post-trigger length and a shot count, then issues a start command. The sequencer first writes the pre-trigger portion. It then keeps writing while it waits for a trigger pulse. Once the trigger arrives it writes the post-trigger portion. After that it spends one cycle on shot bookkeeping and either begins the next record or goes back to idle. A single start therefore yields several consecutive triggered records.

The block drives a write address and a write enable toward an external buffer. It captures the buffer address at which the trigger was accepted, so the host can locate the trigger point. It also keeps a running count of written samples. The buffer memory, the register bus and the trigger source lie outside the block.

Top module: `acq_shot_ctrl`

## Requirements
- R1: The state output uses fixed codes: idle=1, pre-trigger=2, wait-for-trigger=3, post-trigger=4, shot-decrement=5. After reset the state is idle, and the write address, the trigger address and the sample count are all 0.
- R2: The command input is 2 bits, with 1 = start and 2 = stop. A start in idle with `link_ok_i` high moves the state to pre-trigger on the next clock. The same edge clears the write address and the sample count, and loads the shot count. A start while `link_ok_i` is low has no effect.
- R3: A start command in any state other than idle is ignored: the state, the address and the count carry on as if no command had been given.
- R4: A stop command (2) returns the state to idle on the next clock from any state. Stop takes priority over every other transition.
- R5: In pre-trigger the state moves to wait-for-trigger on the edge that accepts the `pre_len_i`-th valid sample. If `pre_len_i` is 0, the move happens on the next clock without waiting for any sample.
- R6: `trig_i` moves the state from wait-for-trigger to post-trigger, and the same edge stores the current write address into `trig_addr_o`. A trigger in any other state changes neither the state nor `trig_addr_o`.
- R7: In post-trigger the state moves to shot-decrement on the edge that accepts the `post_len_i`-th valid sample. If `post_len_i` is 0, the move happens on the next clock.
- R8: Shot-decrement lasts one cycle and writes nothing. It goes to pre-trigger if more than one shot remained, otherwise to idle. A shot count of 0 behaves as 1.
- R9: `wr_en_o` is high exactly when `smp_valid_i` is high and the state is pre-trigger, wait-for-trigger or post-trigger. The write address advances by one after each write and wraps from DEPTH-1 to 0.
- R10: `smp_count_o` increases by one for every write and is cleared only by an accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | A sample is present this cycle |
| trig_i | input | 1 | Trigger pulse |
| cmd_i | input | 2 | Command: 1 start, 2 stop, others none |
| link_ok_i | input | 1 | Sample link synchronized; start is gated by it |
| pre_len_i | input | CNT_W | Pre-trigger sample count |
| post_len_i | input | CNT_W | Post-trigger sample count |
| shots_i | input | SHOT_W | Records per start |
| state_o | output | 3 | Current state code |
| wr_addr_o | output | ADDR_W | Buffer write address |
| wr_en_o | output | 1 | Buffer write enable |
| trig_addr_o | output | ADDR_W | Write address captured at the trigger |
| smp_count_o | output | SCNT_W | Samples written since the last start |

## Verification
The assertions assume that `cmd_i` holds a command for a single cycle at a time, and that the length and shot-count inputs stay constant while a capture runs. The directed tasks drive a command for exactly one cycle and then return it to 0. They load the lengths and the shot count only while the sequencer is idle. The address-stability check also relies on samples being the only thing that moves the address outside idle, so the stimulus never clears the address other than through a start.

// File: rtl/acq_shot_pkg.sv
package acq_shot_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd1,
      ST_PRE  = 3'd2,
      ST_WAIT = 3'd3,
      ST_POST = 3'd4,
      ST_DECR = 3'd5
   } acq_state_e;

   localparam logic [1:0] CMD_START = 2'd1;
   localparam logic [1:0] CMD_STOP  = 2'd2;
endpackage

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
   import acq_shot_pkg::*;
#(
   parameter int SHOT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_i,
   input  logic              link_ok_i,
   input  logic              trig_i,
   input  logic              phase_done_i,
   input  logic [SHOT_W-1:0] shots_i,
   output acq_state_e        state_o,
   output logic              start_o
);
   acq_state_e        state_q, state_d;
   logic [SHOT_W-1:0] left_q;
   logic              more_shots;

   assign more_shots = (left_q > SHOT_W'(1));

   always_comb begin
      state_d = state_q;
      start_o = 1'b0;
      if (cmd_i == CMD_STOP) begin
         state_d = ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: if (cmd_i == CMD_START && link_ok_i) begin
               state_d = ST_PRE;
               start_o = 1'b1;
            end
            ST_PRE:  if (phase_done_i) state_d = ST_WAIT;
            ST_WAIT: if (trig_i)       state_d = ST_POST;
            ST_POST: if (phase_done_i) state_d = ST_DECR;
            ST_DECR: state_d = more_shots ? ST_PRE : ST_IDLE;
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
      end else begin
         state_q <= state_d;
         if (start_o)
            left_q <= shots_i;
         else if (state_q == ST_DECR && left_q != '0)
            left_q <= left_q - SHOT_W'(1);
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/acq_phase_counter.sv
module acq_phase_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active_i,
   input  logic             valid_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             done_o
);
   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [EXT_W-1:0] cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
   assign done_o  = active_i &&
                    ((limit_i == '0) || (valid_i && cnt_inc == {1'b0, limit_i}));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (!active_i) cnt_q <= '0;
      else if (valid_i)   cnt_q <= cnt_inc[CNT_W-1:0];
   end
endmodule

// File: rtl/acq_addr_gen.sv
module acq_addr_gen #(
   parameter int ADDR_W = 4,
   parameter int DEPTH  = 12,
   parameter int SCNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              we_i,
   input  logic              capture_i,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [ADDR_W-1:0] trig_addr_o,
   output logic [SCNT_W-1:0] count_o
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] addr_q, addr_nxt, trig_q;
   logic [SCNT_W-1:0] cnt_q;

   generate
      if (DEPTH == (1 << ADDR_W)) begin : g_wrap_free
         assign addr_nxt = addr_q + ADDR_W'(1);
      end else begin : g_wrap_cmp
         assign addr_nxt = (addr_q == LAST) ? '0 : addr_q + ADDR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         trig_q <= '0;
      end else begin
         if (clear_i) begin
            addr_q <= '0;
            cnt_q  <= '0;
         end else if (we_i) begin
            addr_q <= addr_nxt;
            cnt_q  <= cnt_q + SCNT_W'(1);
         end
         if (capture_i) trig_q <= addr_q;
      end
   end

   assign wr_addr_o   = addr_q;
   assign trig_addr_o = trig_q;
   assign count_o     = cnt_q;
endmodule

// File: rtl/acq_shot_ctrl.sv
module acq_shot_ctrl
   import acq_shot_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DEPTH  = 12,
   parameter int CNT_W  = 8,
   parameter int SHOT_W = 8,
   parameter int SCNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid_i,
   input  logic              trig_i,
   input  logic [1:0]        cmd_i,
   input  logic              link_ok_i,
   input  logic [CNT_W-1:0]  pre_len_i,
   input  logic [CNT_W-1:0]  post_len_i,
   input  logic [SHOT_W-1:0] shots_i,
   output logic [2:0]        state_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] trig_addr_o,
   output logic [SCNT_W-1:0] smp_count_o
);
   generate
      if (DEPTH < 2 || DEPTH > (1 << ADDR_W)) begin : g_bad_depth
         $error("acq_shot_ctrl: DEPTH must lie in 2..2**ADDR_W");
      end
      if (CNT_W < 1 || SHOT_W < 1 || SCNT_W < 1) begin : g_bad_width
         $error("acq_shot_ctrl: counter widths must be positive");
      end
   endgenerate

   acq_state_e       state;
   logic             start, phase_done, phase_active, capturing, capture;
   logic [CNT_W-1:0] phase_limit;

   assign phase_active = (state == ST_PRE) || (state == ST_POST);
   assign phase_limit  = (state == ST_POST) ? post_len_i : pre_len_i;
   assign capturing    = phase_active || (state == ST_WAIT);
   assign wr_en_o      = smp_valid_i && capturing;
   assign capture      = (state == ST_WAIT) && trig_i && (cmd_i != CMD_STOP);

   acq_seq_fsm #(.SHOT_W(SHOT_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_i        (cmd_i),
      .link_ok_i    (link_ok_i),
      .trig_i       (trig_i),
      .phase_done_i (phase_done),
      .shots_i      (shots_i),
      .state_o      (state),
      .start_o      (start)
   );

   acq_phase_counter #(.CNT_W(CNT_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (phase_active),
      .valid_i  (smp_valid_i),
      .limit_i  (phase_limit),
      .done_o   (phase_done)
   );

   acq_addr_gen #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SCNT_W(SCNT_W)) u_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (start),
      .we_i        (wr_en_o),
      .capture_i   (capture),
      .wr_addr_o   (wr_addr_o),
      .trig_addr_o (trig_addr_o),
      .count_o     (smp_count_o)
   );

   assign state_o = state;
endmodule

// File: rtl/acq_shot_ctrl_chk.sv
module acq_shot_ctrl_chk #(
   parameter int ADDR_W = 4,
   parameter int SCNT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_valid_i,
   input logic [1:0]        cmd_i,
   input logic              link_ok_i,
   input logic [2:0]        state_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [ADDR_W-1:0] trig_addr_o,
   input logic [SCNT_W-1:0] smp_count_o
);
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o >= 3'd1 && state_o <= 3'd5)); // R1

   AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 2'd2) |=> (state_o == 3'd1)); // R4

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd1 && !(cmd_i == 2'd1 && link_ok_i)) |=> (state_o == 3'd1)); // R2

   AST_TRIG_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 3'd3) |=> $stable(trig_addr_o)); // R6

   AST_ADDR_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 3'd1 && !smp_valid_i) |=> $stable(wr_addr_o)); // R9

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 3'd1) |=> (smp_count_o == $past(smp_count_o) ||
                             smp_count_o == $past(smp_count_o) + SCNT_W'(1))); // R10
endmodule

bind acq_shot_ctrl acq_shot_ctrl_chk #(.ADDR_W(ADDR_W), .SCNT_W(SCNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .smp_valid_i (smp_valid_i),
   .cmd_i       (cmd_i),
   .link_ok_i   (link_ok_i),
   .state_o     (state_o),
   .wr_addr_o   (wr_addr_o),
   .trig_addr_o (trig_addr_o),
   .smp_count_o (smp_count_o)
);

// File: tb/acq_shot_ctrl_bench.sv
module acq_shot_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0, trig = 1'b0, link = 1'b0;
   logic [1:0]  cmd = 2'd0;
   logic [7:0]  pre = 8'd0, post = 8'd0, shots = 8'd0;
   logic [2:0]  state;
   logic [3:0]  waddr, taddr;
   logic        wen;
   logic [15:0] scount;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   acq_shot_ctrl u_acq_shot_ctrl (
      .clk(clk), .rst_n(rst_n), .smp_valid_i(valid), .trig_i(trig), .cmd_i(cmd),
      .link_ok_i(link), .pre_len_i(pre), .post_len_i(post), .shots_i(shots),
      .state_o(state), .wr_addr_o(waddr), .wr_en_o(wen), .trig_addr_o(taddr),
      .smp_count_o(scount));

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic cfg(int p, int q, int s);
      pre = 8'(p); post = 8'(q); shots = 8'(s);
   endtask

   task automatic start();
      cmd = 2'd1; step(); cmd = 2'd0;
   endtask

   task automatic t_reset();
      chk("R1 reset state", state, 1);
      chk("R1 reset addr", waddr, 0);
      chk("R1 reset trig addr", taddr, 0);
      chk("R1 reset count", scount, 0);
      valid = 1'b1; #1;
      chk("R9 no write in idle", wen, 0);
      valid = 1'b0;
   endtask

   task automatic t_link_gate();
      link = 1'b0; cfg(3, 2, 1);
      start();
      chk("R2 start blocked by link", state, 1);
      link = 1'b1;
   endtask

   task automatic t_single();
      cfg(3, 2, 1); valid = 1'b1;
      start();
      chk("R2 start to pre", state, 2);
      chk("R2 addr cleared", waddr, 0);
      step(); step();
      chk("R5 still pre", state, 2);
      chk("R9 addr advances", waddr, 2);
      step();
      chk("R5 pre done", state, 3);
      chk("R10 count", scount, 3);
      trig = 1'b1; step(); trig = 1'b0;
      chk("R6 to post", state, 4);
      chk("R6 trig addr", taddr, 3);
      step(); step();
      chk("R7 post done", state, 5);
      chk("R9 addr after post", waddr, 6);
      #1 chk("R8 no write in decr", wen, 0);
      step();
      chk("R8 last shot to idle", state, 1);
      chk("R8 decr writes nothing", scount, 6);
      valid = 1'b0;
   endtask

   task automatic t_multi();
      cfg(1, 1, 2); valid = 1'b1;
      start();
      chk("R10 count cleared on start", scount, 0);
      step();
      chk("R5 one sample pre", state, 3);
      trig = 1'b1; step(); trig = 1'b0;
      chk("R6 first trig addr", taddr, 1);
      step();
      chk("R7 to decr", state, 5);
      step();
      chk("R8 shots remain to pre", state, 2);
      chk("R8 addr held in decr", waddr, 3);
      step();
      trig = 1'b1; step(); trig = 1'b0;
      chk("R6 second trig addr", taddr, 4);
      step(); step();
      chk("R8 second shot ends", state, 1);
      chk("R10 multi count", scount, 6);
      valid = 1'b0;
   endtask

   task automatic t_trig_ignored();
      cfg(2, 1, 1); valid = 1'b0;
      start();
      trig = 1'b1; step(); trig = 1'b0;
      chk("R6 trig ignored in pre", state, 2);
      chk("R6 trig addr unchanged", taddr, 4);
      chk("R5 no sample no advance", waddr, 0);
      #1 chk("R9 no valid no write", wen, 0);
      valid = 1'b1; step(); step(); valid = 1'b0;
      chk("R5 pre reached", state, 3);
      cmd = 2'd2; step(); cmd = 2'd0;
      chk("R4 stop from wait", state, 1);
   endtask

   task automatic t_start_busy();
      cfg(2, 1, 1); valid = 1'b1;
      start();
      step();
      cmd = 2'd1; step(); cmd = 2'd0;
      chk("R3 start ignored when busy", state, 3);
      chk("R3 addr not cleared", waddr, 2);
      valid = 1'b0;
      cmd = 2'd2; trig = 1'b1; step(); cmd = 2'd0; trig = 1'b0;
      chk("R4 stop beats trigger", state, 1);
      chk("R4 trig addr untouched", taddr, 4);
   endtask

   task automatic t_zero_len();
      cfg(0, 0, 0); valid = 1'b0;
      start();
      step();
      chk("R5 zero pre", state, 3);
      trig = 1'b1; step(); trig = 1'b0;
      chk("R6 trig at addr 0", taddr, 0);
      step();
      chk("R7 zero post", state, 5);
      step();
      chk("R8 zero shots as one", state, 1);
   endtask

   task automatic t_wrap();
      cfg(14, 1, 1); valid = 1'b1;
      start();
      for (int i = 0; i < 13; i++) step();
      chk("R9 wrap at depth", waddr, 1);
      chk("R10 count past depth", scount, 13);
      chk("R5 long pre pending", state, 2);
      valid = 1'b0;
      cmd = 2'd2; step(); cmd = 2'd0;
      chk("R4 stop from pre", state, 1);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      step();
      t_link_gate();
      t_single();
      t_multi();
      t_trig_ignored();
      t_start_busy();
      t_zero_len();
      t_wrap();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule